// File: doc/BRIEF.md
# Floating-Point Compare Condition Unit

This unit compares two IEEE-754 operands of the same precision and returns a 2-bit condition code. The two operands are either both single precision or both double precision. A start strobe launches one comparison. One cycle later the unit registers the code and pulses done. The code tells the caller whether operand A is equal to, below or above operand B, or whether the pair is unordered because either operand is a NaN.

An unordered result is handled in one of two ways, chosen by a trap-enable mask bit:
- With the mask bit set, the unit raises a one-cycle trap request for the exception logic.
- With the mask bit clear, no trap is raised. Instead the unit sets a sticky accrued-invalid flag.

Software clears that flag only through an explicit status write.

Ordered comparison works on the sign bit and the magnitude field, so no float subtractor is needed. Positive zero and negative zero are treated as equal.

Top module: `fcmp_cond_unit`

## Requirements
- R1: If either operand is a NaN, the code is 3 (unordered). A NaN has an all-ones exponent and a nonzero fraction. In single precision the exponent is bits 30:23 and the fraction is bits 22:0. In double precision the exponent is bits 62:52 and the fraction is bits 51:0.
- R2: When A is below B, the code is 1, meaning only the low code bit is set.
- R3: When A is above B, the code is 2, meaning only the high code bit is set.
- R4: When A equals B, the code is 0. +0 and -0 are equal.
- R5: Ordering follows value for negative numbers and infinities. A negative number is below every positive number, and of two negatives the one with the larger magnitude is lower. -inf is the lowest value and +inf the highest.
- R6: An unordered result with `inv_trap_en`=1 gives a `trap_req` pulse in the same cycle as `done`. It leaves `acc_invalid` unchanged.
- R7: An unordered result with `inv_trap_en`=0 sets `acc_invalid` in the `done` cycle and raises no trap.
- R8: `acc_invalid` is sticky. Ordered compares leave it unchanged. A `stat_wr` loads it from `stat_acc_wdata` on the next edge. If a masked unordered result lands in the same cycle as a write, the flag is set.
- R9: `done` is high for exactly the one cycle after `start`. Without `start`, `cc` holds its value and `trap_req` stays low.
- R10: With `dbl_sel`=0, only bits 31:0 of each operand are used and bits 63:32 have no effect. With `dbl_sel`=1, all 64 bits are used.
- R11: After reset, `cc`=0, `acc_invalid`=0, `trap_req`=0 and `done`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch one comparison |
| dbl_sel | input | 1 | 1 = double precision, 0 = single precision |
| op_a | input | 64 | Operand A (single precision in bits 31:0) |
| op_b | input | 64 | Operand B (single precision in bits 31:0) |
| inv_trap_en | input | 1 | Trap mask bit for invalid (unordered) results |
| stat_wr | input | 1 | Status write strobe for the accrued flag |
| stat_acc_wdata | input | 1 | Value written to the accrued flag |
| cc | output | 2 | Condition code: 0 equal, 1 less, 2 greater, 3 unordered |
| acc_invalid | output | 1 | Sticky accrued-invalid flag |
| trap_req | output | 1 | One-cycle invalid-operation trap request |
| done | output | 1 | One-cycle completion pulse |

## Verification
Pairs of positive numbers in both precisions separate the less, greater and equal codes. Mixed-sign pairs and negative pairs show that the sign-magnitude ordering is correct rather than a raw bit compare: such a compare would rank any negative value above any positive one. Signed zeros, infinities and infinities against NaN probe the exponent edge cases. NaNs on either side, with the mask set and then clear, separate the trap path from the accrued path. Single-precision operands with NaN-like garbage in the upper half confirm that precision select isolates the unused bits.

// File: rtl/fcmp_pkg.sv
`timescale 1ns/1ps
package fcmp_pkg;
  localparam int SP_EXP  = 8;
  localparam int SP_FRAC = 23;
  localparam int DP_EXP  = 11;
  localparam int DP_FRAC = 52;
  localparam int SP_W    = 1 + SP_EXP + SP_FRAC;
  localparam int DP_W    = 1 + DP_EXP + DP_FRAC;
  localparam int MAG_W   = DP_EXP + DP_FRAC;

  typedef enum logic [1:0] {
    CC_EQ = 2'd0,
    CC_LT = 2'd1,
    CC_GT = 2'd2,
    CC_UN = 2'd3
  } cc_e;

  typedef struct packed {
    logic             sign;
    logic             nan;
    logic             zero;
    logic [MAG_W-1:0] mag;
  } opnd_t;
endpackage

// File: rtl/fcmp_unpack.sv
`timescale 1ns/1ps
module fcmp_unpack
  import fcmp_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int FMT_W = 1 + EXP_W + FRAC_W
) (
  input  logic [FMT_W-1:0] word,
  output opnd_t            info
);
  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;

  always_comb begin
    exp_f       = word[FRAC_W +: EXP_W];
    frac_f      = word[FRAC_W-1:0];
    info.sign   = word[FMT_W-1];
    info.nan    = (&exp_f) && (|frac_f);
    info.zero   = ~|{exp_f, frac_f};
    info.mag    = MAG_W'({exp_f, frac_f});
  end
endmodule

// File: rtl/fcmp_order.sv
`timescale 1ns/1ps
module fcmp_order
  import fcmp_pkg::*;
(
  input  opnd_t a,
  input  opnd_t b,
  output cc_e   cc_o
);
  logic mag_lt;

  always_comb begin
    mag_lt = a.mag < b.mag;
    if (a.nan || b.nan)
      cc_o = CC_UN;
    else if (a.zero && b.zero)
      cc_o = CC_EQ;
    else if (a.sign != b.sign)
      cc_o = a.sign ? CC_LT : CC_GT;
    else if (a.mag == b.mag)
      cc_o = CC_EQ;
    else if (mag_lt ^ a.sign)
      cc_o = CC_LT;
    else
      cc_o = CC_GT;
  end
endmodule

// File: rtl/fcmp_status.sv
`timescale 1ns/1ps
module fcmp_status
  import fcmp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  cc_e  cc_in,
  input  logic trap_en,
  input  logic stat_wr,
  input  logic stat_wdata,
  output cc_e  cc_q,
  output logic acc_q,
  output logic trap_q,
  output logic done_q
);
  cc_e  cc_d;
  logic acc_d, trap_d, done_d, unord;

  always_comb begin
    unord  = start && (cc_in == CC_UN);
    cc_d   = start ? cc_in : cc_q;
    acc_d  = (stat_wr ? stat_wdata : acc_q) | (unord & ~trap_en);
    trap_d = unord & trap_en;
    done_d = start;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cc_q   <= CC_EQ;
      acc_q  <= 1'b0;
      trap_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      cc_q   <= cc_d;
      acc_q  <= acc_d;
      trap_q <= trap_d;
      done_q <= done_d;
    end
  end

  p_trap_unord_r6: assert property (@(posedge clk) disable iff (!rst_n)
    trap_q |-> (cc_q == CC_UN) && done_q);
  p_trap_acc_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && trap_en && !stat_wr) |=> $stable(acc_q));
  p_no_trap_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !trap_en) |=> !trap_q);
  p_acc_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !trap_en && cc_in == CC_UN) |=> acc_q);
  p_acc_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_q && !stat_wr) |=> acc_q);
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done_q);
  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !done_q && !trap_q);
  p_cc_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(cc_q));
endmodule

// File: rtl/fcmp_cond_unit.sv
`timescale 1ns/1ps
module fcmp_cond_unit
  import fcmp_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            dbl_sel,
  input  logic [DP_W-1:0] op_a,
  input  logic [DP_W-1:0] op_b,
  input  logic            inv_trap_en,
  input  logic            stat_wr,
  input  logic            stat_acc_wdata,
  output logic [1:0]      cc,
  output logic            acc_invalid,
  output logic            trap_req,
  output logic            done
);
  localparam int N_SIDE = 2;

  opnd_t side [N_SIDE];
  cc_e   cc_comb;
  cc_e   cc_reg;

  for (genvar g = 0; g < N_SIDE; g++) begin : g_side
    logic [DP_W-1:0] word;
    opnd_t sp_i, dp_i;
    assign word = (g == 0) ? op_a : op_b;

    fcmp_unpack #(.EXP_W(SP_EXP), .FRAC_W(SP_FRAC)) u_sp (
      .word (word[SP_W-1:0]),
      .info (sp_i)
    );
    fcmp_unpack #(.EXP_W(DP_EXP), .FRAC_W(DP_FRAC)) u_dp (
      .word (word),
      .info (dp_i)
    );
    assign side[g] = dbl_sel ? dp_i : sp_i;
  end

  fcmp_order u_order (
    .a    (side[0]),
    .b    (side[1]),
    .cc_o (cc_comb)
  );

  fcmp_status u_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .cc_in      (cc_comb),
    .trap_en    (inv_trap_en),
    .stat_wr    (stat_wr),
    .stat_wdata (stat_acc_wdata),
    .cc_q       (cc_reg),
    .acc_q      (acc_invalid),
    .trap_q     (trap_req),
    .done_q     (done)
  );

  assign cc = cc_reg;

  p_nan_unord_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && (side[0].nan || side[1].nan)) |=> (cc == 2'd3));
  p_zero_equal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && side[0].zero && side[1].zero) |=> (cc == 2'd0));
  p_sign_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !side[0].nan && !side[1].nan && side[0].sign && !side[1].sign
     && !(side[0].zero && side[1].zero)) |=> (cc == 2'd1));
endmodule

// File: tb/sim_fcmp_cond_unit.sv
`timescale 1ns/1ps
module sim_fcmp_cond_unit;
  logic        clk = 1'b0;
  logic        rst_n, start, dbl_sel, inv_trap_en, stat_wr, stat_acc_wdata;
  logic [63:0] op_a, op_b;
  logic [1:0]  cc;
  logic        acc_invalid, trap_req, done;
  int          vectors = 0;
  int          fails = 0;
  int          cycles = 0;

  always #2.5 clk = ~clk;

  fcmp_cond_unit u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .dbl_sel(dbl_sel),
    .op_a(op_a), .op_b(op_b), .inv_trap_en(inv_trap_en),
    .stat_wr(stat_wr), .stat_acc_wdata(stat_acc_wdata),
    .cc(cc), .acc_invalid(acc_invalid), .trap_req(trap_req), .done(done)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // drive one compare; returns at the falling edge after the capturing edge
  task automatic run_cmp(input logic [63:0] a, input logic [63:0] b,
                         input logic dbl, input logic te);
    op_a = a; op_b = b; dbl_sel = dbl; inv_trap_en = te; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic cmp_check(input string req, input logic [63:0] a, input logic [63:0] b,
                           input logic dbl, input logic [1:0] exp_cc);
    run_cmp(a, b, dbl, 1'b1);
    chk(req, {62'd0, cc}, {62'd0, exp_cc});
    chk({req, " done"}, {63'd0, done}, 64'd1);
  endtask

  task automatic t_reset;
    chk("R11 cc", {62'd0, cc}, 64'd0);
    chk("R11 acc", {63'd0, acc_invalid}, 64'd0);
    chk("R11 trap", {63'd0, trap_req}, 64'd0);
    chk("R11 done", {63'd0, done}, 64'd0);
  endtask

  task automatic t_single_order;
    cmp_check("R2 sp 1<2", 64'h3F800000, 64'h40000000, 1'b0, 2'd1);
    cmp_check("R3 sp 2>1", 64'h40000000, 64'h3F800000, 1'b0, 2'd2);
    cmp_check("R4 sp 1==1", 64'h3F800000, 64'h3F800000, 1'b0, 2'd0);
  endtask

  task automatic t_double_order;
    cmp_check("R2 dp 1<2", 64'h3FF0000000000000, 64'h4000000000000000, 1'b1, 2'd1);
    cmp_check("R3 dp 2>1", 64'h4000000000000000, 64'h3FF0000000000000, 1'b1, 2'd2);
    cmp_check("R4 dp 2==2", 64'h4000000000000000, 64'h4000000000000000, 1'b1, 2'd0);
  endtask

  task automatic t_signs;
    cmp_check("R5 sp -1<1", 64'hBF800000, 64'h3F800000, 1'b0, 2'd1);
    cmp_check("R5 sp 1>-2", 64'h3F800000, 64'hC0000000, 1'b0, 2'd2);
    cmp_check("R5 sp -2<-1", 64'hC0000000, 64'hBF800000, 1'b0, 2'd1);
    cmp_check("R5 sp -1>-2", 64'hBF800000, 64'hC0000000, 1'b0, 2'd2);
    cmp_check("R5 dp -3<1", 64'hC008000000000000, 64'h3FF0000000000000, 1'b1, 2'd1);
    cmp_check("R5 sp -inf<-2", 64'hFF800000, 64'hC0000000, 1'b0, 2'd1);
    cmp_check("R5 sp +inf>2", 64'h7F800000, 64'h40000000, 1'b0, 2'd2);
    cmp_check("R4 sp inf==inf", 64'h7F800000, 64'h7F800000, 1'b0, 2'd0);
  endtask

  task automatic t_zeros;
    cmp_check("R4 sp +0==-0", 64'h00000000, 64'h80000000, 1'b0, 2'd0);
    cmp_check("R4 sp -0==+0", 64'h80000000, 64'h00000000, 1'b0, 2'd0);
    cmp_check("R4 dp -0==+0", 64'h8000000000000000, 64'h0, 1'b1, 2'd0);
    cmp_check("R5 sp -0<1", 64'h80000000, 64'h3F800000, 1'b0, 2'd1);
  endtask

  task automatic t_nan_trap;
    run_cmp(64'h7FC00000, 64'h3F800000, 1'b0, 1'b1);
    chk("R1 sp nan a", {62'd0, cc}, 64'd3);
    chk("R6 trap", {63'd0, trap_req}, 64'd1);
    chk("R6 acc unchanged", {63'd0, acc_invalid}, 64'd0);
    @(negedge clk);
    chk("R6 trap one cycle", {63'd0, trap_req}, 64'd0);
    run_cmp(64'h3FF0000000000000, 64'h7FF8000000000000, 1'b1, 1'b1);
    chk("R1 dp nan b", {62'd0, cc}, 64'd3);
    chk("R6 trap dp", {63'd0, trap_req}, 64'd1);
    chk("R6 acc dp", {63'd0, acc_invalid}, 64'd0);
    run_cmp(64'h7F800000, 64'h7F800001, 1'b0, 1'b1);
    chk("R1 inf vs nan", {62'd0, cc}, 64'd3);
  endtask

  task automatic t_nan_accrue;
    run_cmp(64'h3F800000, 64'h7FC00000, 1'b0, 1'b0);
    chk("R7 cc", {62'd0, cc}, 64'd3);
    chk("R7 no trap", {63'd0, trap_req}, 64'd0);
    chk("R7 acc set", {63'd0, acc_invalid}, 64'd1);
  endtask

  task automatic t_sticky;
    run_cmp(64'h3F800000, 64'h40000000, 1'b0, 1'b0);
    chk("R8 kept after ordered", {63'd0, acc_invalid}, 64'd1);
    chk("R8 ordered cc", {62'd0, cc}, 64'd1);
    @(negedge clk);
    chk("R8 kept idle", {63'd0, acc_invalid}, 64'd1);
    stat_wr = 1'b1; stat_acc_wdata = 1'b0;
    @(negedge clk);
    stat_wr = 1'b0;
    chk("R8 cleared by write", {63'd0, acc_invalid}, 64'd0);
    stat_wr = 1'b1; stat_acc_wdata = 1'b1;
    @(negedge clk);
    stat_wr = 1'b0;
    chk("R8 written one", {63'd0, acc_invalid}, 64'd1);
    stat_wr = 1'b1; stat_acc_wdata = 1'b0;
    run_cmp(64'h7FC00000, 64'h0, 1'b0, 1'b0);
    stat_wr = 1'b0;
    chk("R8 set wins over clear", {63'd0, acc_invalid}, 64'd1);
    stat_wr = 1'b1; stat_acc_wdata = 1'b0;
    @(negedge clk);
    stat_wr = 1'b0;
    chk("R8 cleared again", {63'd0, acc_invalid}, 64'd0);
  endtask

  task automatic t_precision;
    cmp_check("R10 sp ignores upper", {32'h7FF80000, 32'h3F800000},
              {32'hFFFFFFFF, 32'h40000000}, 1'b0, 2'd1);
    cmp_check("R10 dp uses upper", {32'h7FF80000, 32'h3F800000},
              {32'h00000000, 32'h40000000}, 1'b1, 2'd3);
    cmp_check("R10 sp low nan", {32'h00000000, 32'h7F800010},
              64'h0, 1'b0, 2'd3);
  endtask

  task automatic t_hold;
    cmp_check("R9 setup", 64'h40000000, 64'h3F800000, 1'b0, 2'd2);
    op_a = 64'h0; op_b = 64'h7FC00000;
    @(negedge clk);
    chk("R9 done low", {63'd0, done}, 64'd0);
    chk("R9 cc held", {62'd0, cc}, 64'd2);
    @(negedge clk);
    chk("R9 cc still held", {62'd0, cc}, 64'd2);
    chk("R9 no trap idle", {63'd0, trap_req}, 64'd0);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; dbl_sel = 1'b0; inv_trap_en = 1'b0;
    stat_wr = 1'b0; stat_acc_wdata = 1'b0; op_a = '0; op_b = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single_order();
    t_double_order();
    t_signs();
    t_zeros();
    t_nan_trap();
    t_nan_accrue();
    t_sticky();
    t_precision();
    t_hold();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule